// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in the execute stage of a five-stage in-order pipeline. For each of the two source operands of the instruction about to enter the ALU, it decides where the value comes from. The value can come from the register file read done in decode. It can also come from the result held after execute, which is the newest value, or from the result held after the memory stage, which is the older one. It compares the two source register numbers against the destination numbers of the two later stages. A stage only counts as a source when it will actually write a register, and a result aimed at register zero is never passed on.

The selector is combinational. A thin wrapper applies each 2-bit select to a three-way operand multiplexer, so that one instance hands the ALU both finished operands. Stall generation, the register file and the ALU are outside the block.

Top module: `fwd_operand_unit`

## Requirements
- R1: When no later stage qualifies as a source for an operand, its select is 00 and the operand equals the register file value for that operand.
- R2: Operand A selects 10 and takes the execute-result value when the execute-result stage has its write flag set, its destination is nonzero, and its destination equals the A source register number.
- R3: Operand B selects 10 and takes the execute-result value under the same conditions, compared against the B source register number.
- R4: An operand selects 01 and takes the memory-result value when the memory-result stage has its write flag set, its destination is nonzero and equals that operand's source number, and the execute-result stage does not qualify for that operand.
- R5: When both later stages qualify for the same operand, the execute-result stage wins and the select is 10.
- R6: A stage whose write flag is low is never selected, whatever its destination number.
- R7: A destination of register zero is never selected, even when it equals the source number and the write flag is set.
- R8: The two operands are resolved independently, so A and B may take different sources in the same cycle.
- R9: The select code 11 never appears on either select output.
- R10: Register numbers are 5 bits wide and data paths are 32 bits wide by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs_idx | input | 5 | Source register number for operand A in execute |
| ex_rt_idx | input | 5 | Source register number for operand B in execute |
| exm_wr | input | 1 | Execute-result stage will write a register |
| exm_dst | input | 5 | Destination register number of the execute-result stage |
| mwb_wr | input | 1 | Memory-result stage will write a register |
| mwb_dst | input | 5 | Destination register number of the memory-result stage |
| rf_a_data | input | 32 | Register file value read for operand A |
| rf_b_data | input | 32 | Register file value read for operand B |
| exm_result | input | 32 | Result held in the execute-result stage |
| mwb_result | input | 32 | Result held in the memory-result stage |
| sel_a | output | 2 | Operand A source: 00 register file, 10 execute result, 01 memory result |
| sel_b | output | 2 | Operand B source, same encoding |
| opnd_a | output | 32 | Operand A delivered to the ALU |
| opnd_b | output | 32 | Operand B delivered to the ALU |

## Verification
The sweep covers every combination of source numbers, destinations and write flags drawn from register zero, two small registers and the highest register. This brings out the cases where both stages hit the same source. A selector with the priority reversed would hand the ALU the stale memory-stage value there. It also reaches a matching destination with its write flag low and a matching destination of zero. A design that skipped the flag test, or the zero test, would bypass data that never reaches the register file. Directed cases then give A and B different sources in the same cycle, which catches a design that shares one decision between the two operands.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   typedef enum logic [1:0] {
      SEL_RF  = 2'b00,
      SEL_MWB = 2'b01,
      SEL_EXM = 2'b10
   } fwd_sel_e;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
   parameter int REG_AW    = 5,
   parameter bit SKIP_ZERO = 1'b1
) (
   input  logic              wr_en,
   input  logic [REG_AW-1:0] dst_idx,
   input  logic [REG_AW-1:0] src_idx,
   output logic              hit
);
   localparam logic [REG_AW-1:0] ZERO_IDX = '0;

   generate
      if (SKIP_ZERO) begin : g_skip_zero
         assign hit = wr_en && (dst_idx != ZERO_IDX) && (dst_idx == src_idx);
      end else begin : g_keep_zero
         assign hit = wr_en && (dst_idx == src_idx);
      end
   endgenerate
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
   import fwd_pkg::*;
(
   input  logic     hit_exm,
   input  logic     hit_mwb,
   output fwd_sel_e sel
);
   always_comb begin
      if (hit_exm)      sel = SEL_EXM;
      else if (hit_mwb) sel = SEL_MWB;
      else              sel = SEL_RF;
   end

   always_comb begin
      // R5: the newer stage wins whenever it qualifies
      if (hit_exm) a_r5_newer_wins : assert (sel == SEL_EXM);
      // R4: the older stage only when it hits and the newer one does not
      if (sel == SEL_MWB) a_r4_older_only_alone : assert (hit_mwb && !hit_exm);
   end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
   import fwd_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  fwd_sel_e          sel,
   input  logic [DATA_W-1:0] rf_val,
   input  logic [DATA_W-1:0] exm_val,
   input  logic [DATA_W-1:0] mwb_val,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      unique case (sel)
         SEL_EXM: y = exm_val;
         SEL_MWB: y = mwb_val;
         default: y = rf_val;
      endcase
   end

   always_comb begin
      // R1: register file path when no bypass is chosen
      if (sel == SEL_RF) a_r1_rf_passthru : assert (y == rf_val);
   end
endmodule

// File: rtl/fwd_operand_unit.sv
module fwd_operand_unit
   import fwd_pkg::*;
#(
   parameter int REG_AW    = 5,
   parameter int DATA_W    = 32,
   parameter bit SKIP_ZERO = 1'b1
) (
   input  logic [REG_AW-1:0] ex_rs_idx,
   input  logic [REG_AW-1:0] ex_rt_idx,
   input  logic              exm_wr,
   input  logic [REG_AW-1:0] exm_dst,
   input  logic              mwb_wr,
   input  logic [REG_AW-1:0] mwb_dst,
   input  logic [DATA_W-1:0] rf_a_data,
   input  logic [DATA_W-1:0] rf_b_data,
   input  logic [DATA_W-1:0] exm_result,
   input  logic [DATA_W-1:0] mwb_result,
   output logic [1:0]        sel_a,
   output logic [1:0]        sel_b,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b
);
   localparam int N_SRC = 2;
   localparam logic [REG_AW-1:0] ZERO_IDX = '0;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("fwd_operand_unit: REG_AW out of range");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("fwd_operand_unit: DATA_W must be positive");
      end
   endgenerate

   logic [REG_AW-1:0] src_idx [N_SRC];
   logic [DATA_W-1:0] rf_val  [N_SRC];
   logic [DATA_W-1:0] out_val [N_SRC];
   fwd_sel_e          sel_v   [N_SRC];

   assign src_idx[0] = ex_rs_idx;
   assign src_idx[1] = ex_rt_idx;
   assign rf_val[0]  = rf_a_data;
   assign rf_val[1]  = rf_b_data;

   generate
      for (genvar g = 0; g < N_SRC; g++) begin : g_opnd
         logic hit_exm;
         logic hit_mwb;

         fwd_hit #(.REG_AW(REG_AW), .SKIP_ZERO(SKIP_ZERO)) u_hit_exm (
            .wr_en(exm_wr), .dst_idx(exm_dst), .src_idx(src_idx[g]), .hit(hit_exm));
         fwd_hit #(.REG_AW(REG_AW), .SKIP_ZERO(SKIP_ZERO)) u_hit_mwb (
            .wr_en(mwb_wr), .dst_idx(mwb_dst), .src_idx(src_idx[g]), .hit(hit_mwb));
         fwd_pick u_pick (
            .hit_exm(hit_exm), .hit_mwb(hit_mwb), .sel(sel_v[g]));
         fwd_mux #(.DATA_W(DATA_W)) u_mux (
            .sel(sel_v[g]), .rf_val(rf_val[g]), .exm_val(exm_result),
            .mwb_val(mwb_result), .y(out_val[g]));

         always_comb begin
            // R6: a stage with its write flag low is never the source
            if (sel_v[g] == SEL_EXM) a_r6_exm_writes : assert (exm_wr);
            if (sel_v[g] == SEL_MWB) a_r6_mwb_writes : assert (mwb_wr);
            // R7: register zero is never bypassed
            if (SKIP_ZERO && sel_v[g] != SEL_RF)
               a_r7_no_zero_bypass : assert (src_idx[g] != ZERO_IDX);
         end
      end
   endgenerate

   assign sel_a  = sel_v[0];
   assign sel_b  = sel_v[1];
   assign opnd_a = out_val[0];
   assign opnd_b = out_val[1];

   always_comb begin
      // R9: the unused code never leaves the block
      a_r9_no_code3 : assert (sel_a != 2'b11 && sel_b != 2'b11);
      // R2: an A bypass from the newer stage needs a destination match
      if (sel_a == 2'b10) a_r2_a_match : assert (exm_dst == ex_rs_idx);
      // R3: a B bypass from the newer stage needs a destination match
      if (sel_b == 2'b10) a_r3_b_match : assert (exm_dst == ex_rt_idx);
   end
endmodule

// File: tb/tb_fwd_operand_unit.sv
module tb_fwd_operand_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [4:0]  ex_rs_idx, ex_rt_idx, exm_dst, mwb_dst;
   logic        exm_wr, mwb_wr;
   logic [31:0] rf_a_data, rf_b_data, exm_result, mwb_result;
   logic [1:0]  sel_a, sel_b;
   logic [31:0] opnd_a, opnd_b;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   fwd_operand_unit dut (
      .ex_rs_idx(ex_rs_idx), .ex_rt_idx(ex_rt_idx),
      .exm_wr(exm_wr), .exm_dst(exm_dst),
      .mwb_wr(mwb_wr), .mwb_dst(mwb_dst),
      .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
      .exm_result(exm_result), .mwb_result(mwb_result),
      .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b));

   function automatic logic [1:0] want_sel(logic [4:0] src);
      if (exm_wr && exm_dst != 5'd0 && exm_dst == src) return 2'b10;
      if (mwb_wr && mwb_dst != 5'd0 && mwb_dst == src) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic [31:0] want_val(logic [1:0] s, logic [31:0] rf);
      if (s == 2'b10) return exm_result;
      if (s == 2'b01) return mwb_result;
      return rf;
   endfunction

   function automatic string tag_for(logic [4:0] src, bit is_b);
      bit e = exm_wr && exm_dst != 0 && exm_dst == src;
      bit m = mwb_wr && mwb_dst != 0 && mwb_dst == src;
      if (e && m) return "R5";
      if (e) return is_b ? "R3" : "R2";
      if (m) return "R4";
      if ((exm_dst == src || mwb_dst == src) && src == 0) return "R7";
      if ((exm_dst == src && !exm_wr) || (mwb_dst == src && !mwb_wr)) return "R6";
      return "R1";
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_both();
      logic [1:0] ea = want_sel(ex_rs_idx);
      logic [1:0] eb = want_sel(ex_rt_idx);
      check(tag_for(ex_rs_idx, 1'b0), {30'd0, sel_a}, {30'd0, ea});
      check(tag_for(ex_rt_idx, 1'b1), {30'd0, sel_b}, {30'd0, eb});
      check(tag_for(ex_rs_idx, 1'b0), opnd_a, want_val(ea, rf_a_data));
      check(tag_for(ex_rt_idx, 1'b1), opnd_b, want_val(eb, rf_b_data));
      check("R9", {31'd0, (sel_a == 2'b11) || (sel_b == 2'b11)}, 32'd0);
   endtask

   task automatic drive(logic [4:0] rs, logic [4:0] rt, logic ew, logic [4:0] ed,
                        logic mw, logic [4:0] md);
      @(posedge clk);
      ex_rs_idx = rs; ex_rt_idx = rt;
      exm_wr = ew; exm_dst = ed; mwb_wr = mw; mwb_dst = md;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [4:0] pick [4];
      pick[0] = 5'd0; pick[1] = 5'd1; pick[2] = 5'd2; pick[3] = 5'd31;
      ex_rs_idx = 0; ex_rt_idx = 0; exm_wr = 0; exm_dst = 0; mwb_wr = 0; mwb_dst = 0;
      rf_a_data = 32'hAAAA_0001; rf_b_data = 32'hBBBB_0002;
      exm_result = 32'hE0E0_1234; mwb_result = 32'h5050_9876;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R1: idle state, nothing writes
      drive(5'd3, 5'd4, 1'b0, 5'd0, 1'b0, 5'd0);
      check("R1", {30'd0, sel_a}, 32'd0);
      check("R1", opnd_b, rf_b_data);

      // R8: A from newer stage, B from older stage at once
      drive(5'd7, 5'd9, 1'b1, 5'd7, 1'b1, 5'd9);
      check("R8", {30'd0, sel_a}, 32'd2);
      check("R8", {30'd0, sel_b}, 32'd1);
      check("R8", opnd_a, exm_result);
      check("R8", opnd_b, mwb_result);

      // R5: both stages target the same register
      drive(5'd12, 5'd12, 1'b1, 5'd12, 1'b1, 5'd12);
      check("R5", opnd_a, exm_result);
      check("R5", opnd_b, exm_result);

      // R6: newer stage matches but does not write, older one does
      drive(5'd5, 5'd6, 1'b0, 5'd5, 1'b1, 5'd5);
      check("R6", {30'd0, sel_a}, 32'd1);
      check("R6", opnd_a, mwb_result);

      // R7: register zero written by both stages
      drive(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
      check("R7", opnd_a, rf_a_data);
      check("R7", opnd_b, rf_b_data);

      // R10: the top register number and full data width pass through
      exm_result = 32'hFFFF_FFFF;
      drive(5'd31, 5'd30, 1'b1, 5'd31, 1'b0, 5'd30);
      check("R10", opnd_a, 32'hFFFF_FFFF);
      check("R10", {30'd0, sel_b}, 32'd0);

      // Sweep over a small register set, all flag combinations (R1..R9)
      for (int i = 0; i < 1024; i++) begin
         rf_a_data  = 32'hA000_0000 | i;
         rf_b_data  = 32'hB000_0000 | i;
         exm_result = 32'hE000_0000 | i;
         mwb_result = 32'h7000_0000 | i;
         drive(pick[i[1:0]], pick[i[3:2]], i[8], pick[i[5:4]], i[9], pick[i[7:6]]);
         check_both();
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule